// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block drives the address of a synchronous memory through a short burst. A load event captures a full starting address. The event is a request from either of two independent sources: a processor-side strobe or a cache-controller-side strobe. The same event also captures a chip-select bit and the burst ordering to use. On each later clock where the advance input is high, the block steps a two-bit beat counter. It also recomputes the low address bits from the captured start value. The upper address bits stay as they were loaded.

Two orderings are supported. In interleaved order, the low bits are the start value XOR the beat number. In linear order, they are the start value plus the beat number, wrapping modulo four. The block samples the order select only on a load, so a change on that input in the middle of a burst leaves the running sequence alone. All outputs come straight from registers.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_out`, `beat_cnt` and `cs_out` become zero on that edge.
- R2: `proc_strb` high alone at a rising edge sets `addr_out` to `addr_in`, `beat_cnt` to 0 and `cs_out` to `cs_in` after that edge.
- R3: `ctrl_strb` high alone at a rising edge has the same load effect as R2.
- R4: With both strobes high at one edge, the block performs a single load as in R2, and `adv` has no effect on that edge.
- R5: With no strobe and `adv` high, `beat_cnt` increments by one modulo 4.
- R6: With no strobe and `adv` low, `addr_out`, `beat_cnt` and `cs_out` keep their values.
- R7: Without a strobe, `addr_out` bits above bit 1 never change. An advance never carries into them.
- R8: If `order_sel` was 1 at the load, the low two bits of `addr_out` equal start XOR `beat_cnt`.
- R9: If `order_sel` was 0 at the load, the low two bits of `addr_out` equal (start + `beat_cnt`) mod 4.
- R10: `order_sel` is sampled only at a load. Changing it during a burst does not alter the sequence.
- R11: After four advances, the low bits return to the start value and `beat_cnt` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strb | input | 1 | Processor-side load strobe, active high |
| ctrl_strb | input | 1 | Controller-side load strobe, active high |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = interleaved, 0 = linear; sampled at load |
| cs_in | input | 1 | Chip select captured at load |
| addr_in | input | ADDR_W | Starting address |
| addr_out | output | ADDR_W | Registered current address |
| beat_cnt | output | BEAT_W | Registered beat number within the burst |
| cs_out | output | 1 | Registered chip select |

## Verification
The bench aims at the following corner cases.
- Odd start values. These are the only starts where the two orderings differ at the first advance, so a swapped or merged order function shows up there.
- Start value 3 in linear order. Here a carry into bit 2 would corrupt the upper address.
- Advances that arrive together with one or both strobes. A design that honoured the advance would leave the beat count at 1 instead of 0.
- A toggle of the order select in the middle of a burst. A design that read the pin live would jump to the other sequence.
- Full wrap runs and idle holds. These expose a counter that saturates, or an address that drifts while it should hold.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low-bit address of a beat, computed from the start value and beat number.
  function automatic logic [1:0] beat_low2(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORD_INTERLEAVE) r = start ^ beat;
    else                       r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/burst_strobe_ctrl.sv
module burst_strobe_ctrl (
  input  logic proc_strb,
  input  logic ctrl_strb,
  input  logic adv,
  output logic load_en,
  output logic step_en
);
  // Either strobe loads; a load always wins over an advance.
  always_comb begin
    load_en = proc_strb | ctrl_strb;
    step_en = adv & ~load_en;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [BEAT_W-1:0] start_in,
  input  logic              order_in,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] low_next,
  output logic              order_q
);
  import burst_pkg::*;

  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_inc;

  always_comb begin
    beat_inc = beat_q + {{(BEAT_W-1){1'b0}}, 1'b1};
    if (order_q) low_next = start_q ^ beat_inc;
    else         low_next = start_q + beat_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      start_q <= '0;
      order_q <= ORD_LINEAR;
    end else if (load_en) begin
      beat_q  <= '0;
      start_q <= start_in;
      order_q <= order_in;
    end else if (step_en) begin
      beat_q  <= beat_inc;
    end
  end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cs_in,
  input  logic [BEAT_W-1:0] low_next,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cs_q
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      cs_q <= 1'b0;
    end else if (load_en) begin
      hi_q <= addr_in[ADDR_W-1:BEAT_W];
      lo_q <= addr_in[BEAT_W-1:0];
      cs_q <= cs_in;
    end else if (step_en) begin
      lo_q <= low_next;
    end
  end

  assign addr_q = {hi_q, lo_q};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_strb,
  input  logic              ctrl_strb,
  input  logic              adv,
  input  logic              order_sel,
  input  logic              cs_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat_cnt,
  output logic              cs_out
);
  logic load_en;
  logic step_en;
  logic [BEAT_W-1:0] low_next;
  logic order_q;

  burst_strobe_ctrl u_ctrl (
    .proc_strb (proc_strb),
    .ctrl_strb (ctrl_strb),
    .adv       (adv),
    .load_en   (load_en),
    .step_en   (step_en)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .step_en  (step_en),
    .start_in (addr_in[BEAT_W-1:0]),
    .order_in (order_sel),
    .beat_q   (beat_cnt),
    .low_next (low_next),
    .order_q  (order_q)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_areg (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .step_en  (step_en),
    .addr_in  (addr_in),
    .cs_in    (cs_in),
    .low_next (low_next),
    .addr_q   (addr_out),
    .cs_q     (cs_out)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_strb,
  input logic              ctrl_strb,
  input logic              adv,
  input logic              cs_in,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [BEAT_W-1:0] beat_cnt,
  input logic              cs_out,
  input logic              order_q
);
  logic any_strb;
  assign any_strb = proc_strb | ctrl_strb;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && beat_cnt == '0 && !cs_out)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    any_strb |=> (addr_out == $past(addr_in) && beat_cnt == '0 && cs_out == $past(cs_in))); // R4

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!any_strb && adv) |=> beat_cnt == $past(beat_cnt) + 1'b1); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!any_strb && !adv) |=> ($stable(addr_out) && $stable(beat_cnt) && $stable(cs_out))); // R6

  AST_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    !any_strb |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])); // R7

  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!any_strb && adv && order_q) |=>
      addr_out[BEAT_W-1:0] == ($past(addr_out[BEAT_W-1:0]) ^ $past(beat_cnt) ^ ($past(beat_cnt) + 1'b1))); // R8

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!any_strb && adv && !order_q) |=>
      addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 1'b1); // R9
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .proc_strb (proc_strb),
  .ctrl_strb (ctrl_strb),
  .adv       (adv),
  .cs_in     (cs_in),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .beat_cnt  (beat_cnt),
  .cs_out    (cs_out),
  .order_q   (order_q)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst, proc_strb, ctrl_strb, adv, order_sel, cs_in;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [1:0] beat_cnt;
  logic cs_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Behavioural reference state
  int m_hi, m_start, m_beat, m_order, m_cs;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
    .clk(clk), .rst(rst), .proc_strb(proc_strb), .ctrl_strb(ctrl_strb),
    .adv(adv), .order_sel(order_sel), .cs_in(cs_in), .addr_in(addr_in),
    .addr_out(addr_out), .beat_cnt(beat_cnt), .cs_out(cs_out)
  );

  function automatic int model_low();
    if (m_order != 0) return (m_start ^ m_beat) & 3;
    return (m_start + m_beat) % 4;
  endfunction

  task automatic check(string tag);
    int exp_addr;
    exp_addr = (m_hi << 2) | model_low();
    n_checks++;
    if (addr_out !== exp_addr[AW-1:0] || beat_cnt !== m_beat[1:0] || cs_out !== m_cs[0]) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d cs=%0b expected addr=%h beat=%0d cs=%0d",
               tag, addr_out, beat_cnt, cs_out, exp_addr[AW-1:0], m_beat, m_cs);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic cyc(bit r, bit ps, bit cs_s, bit a, bit ord, bit c, int ad, string tag);
    rst = r; proc_strb = ps; ctrl_strb = cs_s; adv = a; order_sel = ord; cs_in = c;
    addr_in = ad[AW-1:0];
    @(posedge clk);
    if (r) begin
      m_hi = 0; m_start = 0; m_beat = 0; m_order = 0; m_cs = 0;
    end else if (ps || cs_s) begin
      m_hi = (ad >> 2) & ((1 << (AW-2)) - 1); m_start = ad & 3; m_beat = 0;
      m_order = ord; m_cs = c;
    end else if (a) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    m_hi = 0; m_start = 0; m_beat = 0; m_order = 0; m_cs = 0;
    rst = 1; proc_strb = 0; ctrl_strb = 0; adv = 0; order_sel = 0; cs_in = 0; addr_in = '0;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0, 0, "R1 reset");
    cyc(1, 1, 1, 1, 1, 1, 'h1ffff, "R1 reset over strobe");

    // Processor load, interleaved, odd start, full wrap
    cyc(0, 1, 0, 0, 1, 1, 'h12345, "R2 proc load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 1, 0, "R8 interleave step");
    check("R11 wrap to start");

    // Controller load, linear, start 3 (carry hazard)
    cyc(0, 0, 1, 0, 0, 0, 'h0abcf, "R3 ctrl load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 1, 'h1ffff, "R9 linear step R7");
    check("R11 linear wrap");

    // Hold with no advance
    cyc(0, 0, 0, 1, 0, 0, 0, "R5 step");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1, 'h1234, "R6 hold");

    // Both strobes with advance: adv ignored
    cyc(0, 1, 1, 1, 1, 1, 'h00001, "R4 dual strobe");
    cyc(0, 1, 1, 1, 0, 0, 'h00006, "R4 dual strobe reload");

    // Mode toggled mid-burst (linear captured, odd start)
    cyc(0, 1, 0, 0, 0, 1, 'h15555, "R2 load for R10");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, i[0], 1, 0, "R10 order pin ignored");

    // Interleaved with each start, mixed adv gaps
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 1, 1, 1, s[0], 'h08000 + s, "R3 ctrl load R4");
      for (int k = 0; k < 5; k++) cyc(0, 0, 0, k != 2, 0, 0, 0, "R8 R5 R6 sequence");
    end
    for (int s = 0; s < 4; s++) begin
      cyc(0, 1, 0, 0, 0, 1, 'h07ffc + s, "R2 proc load linear");
      for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1, 0, 0, "R9 R7 linear");
    end

    // Reset mid-burst
    cyc(0, 0, 0, 1, 0, 0, 0, "R5 step");
    cyc(1, 0, 0, 1, 0, 0, 0, "R1 reset mid-burst");

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule